// File: doc/BRIEF.md
# Byte-Wide SPI Port with Completion and Collision Flags

This block is an 8-bit synchronous serial port for a small microcontroller. Software reaches it through three byte-wide registers: control, status and data. It can act as master or slave. As master it makes the serial clock from the system clock through one of four fixed dividers and drives its own active-low select line for the whole byte. As slave it follows an external clock and select, after passing them through a synchronizer. Both clock polarities and both clock phases are supported. Bits always move most-significant first.

When a byte completes, a done flag is set and the received byte is made readable. An interrupt request is raised when the port's interrupt enable and the chip-level serial interrupt enable are both set. A write to the data register while a byte is moving is dropped and sets a collision flag. Both flags stay set until software writes a zero to their bit.

Top module: `spi_port`

## Requirements
- R1: After reset the control, status and data read values are 0x00, `ss_n_o` is 1, `sck_o` is 0 and `irq_o` is 0.
- R2: `reg_sel` 0 is control: bit 7 interrupt enable, bit 6 port enable, bit 5 reserved (reads 0), bit 4 master, bit 3 clock polarity, bit 2 clock phase, bits 1:0 rate code. `reg_sel` 1 is status: bit 7 done flag, bit 6 collision flag, bits 5:0 read 0. `reg_sel` 2 is data: a write supplies the byte to send and a read returns the last byte received. `reg_sel` 3 reads 0x00.
- R3: In master mode with the port enabled and idle, a data write drives `ss_n_o` low from the next cycle and sends the written byte on `mosi_o`, MSB first. `ss_n_o` returns high in the cycle that follows the last (sixteenth) clock edge.
- R4: As master, one `sck_o` period lasts 4, 16, 64 or 128 system clock cycles for rate codes 0, 1, 2 and 3.
- R5: While no transfer runs, `sck_o` rests at the polarity bit: low for 0, high for 1.
- R6: With phase 0, the first bit is valid before the first edge, bits are sampled on leading edges and change on trailing edges. With phase 1, bits change on leading edges and are sampled on trailing edges.
- R7: The byte sampled MSB first from the input line is readable from the data register in the same cycle the done flag rises.
- R8: The done flag is set when a byte completes. `irq_o` equals done flag AND interrupt enable AND `serial_ie_i`.
- R9: A data write while a byte is moving sets the collision flag. The byte in flight is unaffected, and the written value is discarded.
- R10: Writing 0 to status bit 7 or bit 6 clears that flag. Writing 1 leaves it unchanged. A flag set in the same cycle wins over the clear.
- R11: In slave mode (master bit 0, port enabled), a low `ss_n_i` starts a byte clocked by `sck_i`. The rate code has no effect. The preloaded byte goes out on `miso_o` MSB first, the byte from `mosi_i` becomes readable, and the done flag is set. `sck_o` stays at its idle level.
- R12: In slave mode, if `ss_n_i` goes high before the sixteenth edge, the byte is abandoned with no flag. The next selection starts again from the first bit.
- R13: With the port enable bit 0, data writes start nothing and `ss_n_o` and `sck_o` stay idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| serial_ie_i | input | 1 | Chip-level serial interrupt enable |
| irq_o | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock driven in master mode |
| mosi_o | output | 1 | Serial data out in master mode |
| miso_i | input | 1 | Serial data in in master mode |
| ss_n_o | output | 1 | Active-low select driven in master mode |
| sck_i | input | 1 | Serial clock received in slave mode |
| mosi_i | input | 1 | Serial data in in slave mode |
| miso_o | output | 1 | Serial data out in slave mode |
| ss_n_i | input | 1 | Active-low select received in slave mode |

## Verification
The embedded properties check on every cycle that the serial clock settles to the polarity level when idle, that the edge counter starts at zero for each byte, and that the busy state drops right after the final edge. They also check that completion sets the done flag, that a mid-byte data write sets the collision flag, and that a zero write clears the done flag. Only the bench's scenarios can show the divider periods, the bit order and the sample or change edges in all four clock modes, and the value of the received byte. The same holds for the slave path through the synchronizer, the abort on early deselection, and the fact that a collided or disabled write changes nothing on the wires.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    localparam int BYTE_W   = 8;
    localparam int EDGE_N   = 2 * BYTE_W;
    localparam int EDGE_W   = $clog2(EDGE_N);
    localparam int HALF_W   = 7;
    localparam int DONE_BIT = 7;
    localparam int COLL_BIT = 6;

    typedef struct packed {
        logic       irq_en;
        logic       enable;
        logic       rsvd;
        logic       master;
        logic       cpol;
        logic       cpha;
        logic [1:0] rate;
    } ctrl_t;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_DATA = 2'd2,
        SEL_NONE = 2'd3
    } sel_e;

    // system clock cycles per half period of the master serial clock
    function automatic logic [HALF_W-1:0] half_period(input logic [1:0] code);
        case (code)
            2'd0:    return HALF_W'(2);
            2'd1:    return HALF_W'(8);
            2'd2:    return HALF_W'(32);
            default: return HALF_W'(64);
        endcase
    endfunction

endpackage

// File: rtl/spi_sck_gen.sv
module spi_sck_gen
    import spi_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       cpol_i,
    input  logic [1:0] rate_i,
    output logic       sck_o,
    output logic       edge_o
);

    typedef struct packed {
        logic [HALF_W-1:0] cnt;
        logic              sck;
    } gen_t;

    gen_t              state_d, state_q;
    logic [HALF_W-1:0] half;

    always_comb begin
        half    = half_period(rate_i);
        state_d = state_q;
        edge_o  = 1'b0;
        if (!run_i) begin
            state_d.cnt = '0;
            state_d.sck = cpol_i;
        end else if (state_q.cnt >= half - HALF_W'(1)) begin
            state_d.cnt = '0;
            state_d.sck = ~state_q.sck;
            edge_o      = 1'b1;
        end else begin
            state_d.cnt = state_q.cnt + HALF_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign sck_o = state_q.sck;

    // R5
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (sck_o == $past(cpol_i)));

endmodule

// File: rtl/spi_slave_front.sv
module spi_slave_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic ss_n_i,
    input  logic mosi_i,
    output logic sel_o,
    output logic sel_rise_o,
    output logic edge_o,
    output logic mosi_o
);

    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sck_sync;
        logic [SYNC_STAGES-1:0] ss_sync;
        logic [SYNC_STAGES-1:0] mosi_sync;
        logic                   sck_prev;
        logic                   sel_prev;
    } front_t;

    front_t state_d, state_q;

    always_comb begin
        state_d           = state_q;
        state_d.sck_sync  = {state_q.sck_sync[LAST-1:0],  sck_i};
        state_d.ss_sync   = {state_q.ss_sync[LAST-1:0],   ss_n_i};
        state_d.mosi_sync = {state_q.mosi_sync[LAST-1:0], mosi_i};
        state_d.sck_prev  = state_q.sck_sync[LAST];
        state_d.sel_prev  = sel_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q          <= '0;
            state_q.ss_sync  <= '1;
            state_q.sel_prev <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sel_o      = ~state_q.ss_sync[LAST];
    assign sel_rise_o = sel_o & ~state_q.sel_prev;
    assign edge_o     = sel_o & state_q.sel_prev &
                        (state_q.sck_sync[LAST] != state_q.sck_prev);
    assign mosi_o     = state_q.mosi_sync[LAST];

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
    import spi_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] load_data_i,
    input  logic              start_i,
    input  logic              abort_i,
    input  logic              edge_i,
    input  logic              cpha_i,
    input  logic              sdi_i,
    output logic              sdo_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [BYTE_W-1:0] rx_o
);

    typedef struct packed {
        logic [BYTE_W-1:0] tx;
        logic [BYTE_W-1:0] rx;
        logic [EDGE_W-1:0] idx;
        logic              busy;
    } shf_t;

    shf_t state_d, state_q;
    logic odd_edge, sample_now, shift_now, last_edge;

    always_comb begin
        state_d    = state_q;
        odd_edge   = state_q.idx[0];
        sample_now = cpha_i ? odd_edge : ~odd_edge;
        shift_now  = cpha_i ? (~odd_edge && (state_q.idx != '0)) : odd_edge;
        last_edge  = (state_q.idx == EDGE_W'(EDGE_N - 1));
        done_o     = 1'b0;

        if (load_i) state_d.tx = load_data_i;

        if (start_i) begin
            state_d.busy = 1'b1;
            state_d.idx  = '0;
        end else if (abort_i) begin
            state_d.busy = 1'b0;
        end else if (state_q.busy && edge_i) begin
            if (sample_now) state_d.rx = {state_q.rx[BYTE_W-2:0], sdi_i};
            if (shift_now)  state_d.tx = {state_q.tx[BYTE_W-2:0], 1'b0};
            state_d.idx = state_q.idx + EDGE_W'(1);
            if (last_edge) begin
                state_d.busy = 1'b0;
                done_o       = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign sdo_o  = state_q.tx[BYTE_W-1];
    assign busy_o = state_q.busy;
    assign rx_o   = state_d.rx;

    // R3
    idx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (state_q.idx == '0));

    // R3
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  reg_sel,
    input  logic        reg_wr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        serial_ie_i,
    output logic        irq_o,
    output logic        sck_o,
    output logic        mosi_o,
    input  logic        miso_i,
    output logic        ss_n_o,
    input  logic        sck_i,
    input  logic        mosi_i,
    output logic        miso_o,
    input  logic        ss_n_i
);

    typedef struct packed {
        ctrl_t             ctrl;
        logic              done_flag;
        logic              coll_flag;
        logic [BYTE_W-1:0] rxd;
    } port_t;

    port_t             state_d, state_q;
    sel_e              sel;
    logic              ctrl_wr, stat_wr, data_wr;
    logic              busy, done, load, start, abort, collide;
    logic              m_edge, m_run, s_sel, s_rise, s_edge, s_mosi;
    logic              edge_mux, sdi_mux, sdo;
    logic [BYTE_W-1:0] rx_byte;
    logic              unused_wbits;

    assign sel          = sel_e'(reg_sel);
    assign ctrl_wr      = reg_wr && (sel == SEL_CTRL);
    assign stat_wr      = reg_wr && (sel == SEL_STAT);
    assign data_wr      = reg_wr && (sel == SEL_DATA);
    assign unused_wbits = ^reg_wdata[5:0];

    assign load    = data_wr && state_q.ctrl.enable && !busy;
    assign start   = state_q.ctrl.master ? load
                   : (state_q.ctrl.enable && s_rise && !busy);
    assign abort   = busy && (!state_q.ctrl.enable || (!state_q.ctrl.master && !s_sel));
    assign collide = data_wr && busy;
    assign m_run   = busy && state_q.ctrl.master;
    assign edge_mux = state_q.ctrl.master ? m_edge : s_edge;
    assign sdi_mux  = state_q.ctrl.master ? miso_i : s_mosi;

    spi_sck_gen u_sck_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (m_run),
        .cpol_i (state_q.ctrl.cpol),
        .rate_i (state_q.ctrl.rate),
        .sck_o  (sck_o),
        .edge_o (m_edge)
    );

    spi_slave_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_i      (sck_i),
        .ss_n_i     (ss_n_i),
        .mosi_i     (mosi_i),
        .sel_o      (s_sel),
        .sel_rise_o (s_rise),
        .edge_o     (s_edge),
        .mosi_o     (s_mosi)
    );

    spi_shifter u_shifter (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .load_data_i (reg_wdata),
        .start_i     (start),
        .abort_i     (abort),
        .edge_i      (edge_mux),
        .cpha_i      (state_q.ctrl.cpha),
        .sdi_i       (sdi_mux),
        .sdo_o       (sdo),
        .busy_o      (busy),
        .done_o      (done),
        .rx_o        (rx_byte)
    );

    always_comb begin
        state_d = state_q;
        if (ctrl_wr) begin
            state_d.ctrl      = ctrl_t'(reg_wdata);
            state_d.ctrl.rsvd = 1'b0;
        end
        if (stat_wr && !reg_wdata[DONE_BIT]) state_d.done_flag = 1'b0;
        if (stat_wr && !reg_wdata[COLL_BIT]) state_d.coll_flag = 1'b0;
        if (done) begin
            state_d.done_flag = 1'b1;
            state_d.rxd       = rx_byte;
        end
        if (collide) state_d.coll_flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_comb begin
        case (sel)
            SEL_CTRL: reg_rdata = state_q.ctrl;
            SEL_STAT: reg_rdata = {state_q.done_flag, state_q.coll_flag, 6'b0};
            SEL_DATA: reg_rdata = state_q.rxd;
            default:  reg_rdata = '0;
        endcase
    end

    assign irq_o  = state_q.done_flag && state_q.ctrl.irq_en && serial_ie_i;
    assign ss_n_o = ~m_run;
    assign mosi_o = sdo;
    assign miso_o = sdo;

    // R8
    done_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> state_q.done_flag);

    // R9
    coll_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && busy) |=> state_q.coll_flag);

    // R10
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !reg_wdata[DONE_BIT] && !done) |=> !state_q.done_flag);

endmodule

// File: tb/spi_port_tb.sv
module spi_port_tb;
    import spi_port_pkg::*;

    localparam logic [7:0] C_IE   = 8'h80;
    localparam logic [7:0] C_EN   = 8'h40;
    localparam logic [7:0] C_MS   = 8'h10;
    localparam logic [7:0] C_CPOL = 8'h08;
    localparam logic [7:0] C_CPHA = 8'h04;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       serial_ie_i = 1'b1;
    logic       irq_o, sck_o, mosi_o, ss_n_o, miso_o;
    logic       miso_i = 1'b0;
    logic       sck_i = 1'b0;
    logic       mosi_i = 1'b0;
    logic       ss_n_i = 1'b1;

    int     checks = 0;
    int     errors = 0;
    longint cyc = 0;
    logic   finished = 1'b0;

    // serial-side model state (acts as slave for master tests)
    logic       cpol_tb = 1'b0, cpha_tb = 1'b0;
    logic [7:0] next_miso = 8'h00;
    logic [7:0] mdl_tx = 8'h00, mdl_rx = 8'h00;
    int         mdl_cnt = 0;
    logic       mdl_ss_prev = 1'b1, mdl_sck_prev = 1'b0;
    logic [7:0] exp_q[$];

    spi_port u_dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .serial_ie_i(serial_ie_i),
        .irq_o(irq_o), .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i),
        .ss_n_o(ss_n_o), .sck_i(sck_i), .mosi_i(mosi_i), .miso_o(miso_o),
        .ss_n_i(ss_n_i)
    );

    always @(posedge clk) cyc++;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // monitor + scoreboard: serial slave model that pops expected MOSI bytes
    always @(sck_o or ss_n_o) begin
        if (rst_n === 1'b1) begin
            if (ss_n_o === 1'b0 && mdl_ss_prev !== 1'b0) begin
                mdl_tx  = next_miso;
                mdl_rx  = 8'h00;
                mdl_cnt = 0;
                miso_i  = mdl_tx[7];
            end else if (mdl_ss_prev === 1'b0 && sck_o !== mdl_sck_prev) begin
                if ((sck_o != cpol_tb) ^ cpha_tb) begin
                    mdl_rx = {mdl_rx[6:0], mosi_o};
                end else if (!(cpha_tb && mdl_cnt == 0)) begin
                    mdl_tx = {mdl_tx[6:0], 1'b0};
                    miso_i = mdl_tx[7];
                end
                mdl_cnt++;
            end
            if (ss_n_o === 1'b1 && mdl_ss_prev === 1'b0) begin
                if (exp_q.size() == 0) check("R3 unexpected frame", 1, 0);
                else check("R3/R6 mosi byte", mdl_rx, exp_q.pop_front());
                check("R3 edge count", mdl_cnt, 16);
            end
        end
        mdl_ss_prev  = ss_n_o;
        mdl_sck_prev = sck_o;
    end

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [7:0] d);
        @(negedge clk);
        reg_sel = s;
        #1 d = reg_rdata;
    endtask

    task automatic set_mode(input logic [7:0] c);
        cpol_tb = c[3];
        cpha_tb = c[2];
        wr(SEL_CTRL, c);
    endtask

    // driver: master transfer, pushes the expected MOSI byte for the monitor
    task automatic mxfer(input logic [7:0] tx, input logic [7:0] sl);
        logic [7:0] v;
        next_miso = sl;
        exp_q.push_back(tx);
        wr(SEL_DATA, tx);
        @(posedge ss_n_o);
        @(negedge clk);
        rd(SEL_STAT, v); check("R8 done flag", v, 8'h80);
        rd(SEL_DATA, v); check("R7 received byte", v, sl);
        wr(SEL_STAT, 8'h00);
        rd(SEL_STAT, v); check("R10 cleared", v, 8'h00);
    endtask

    // bench acts as master toward the DUT slave
    task automatic sxfer(input logic pol, input logic pha, input logic [7:0] mb,
                         output logic [7:0] got);
        got = 8'h00;
        @(negedge clk);
        sck_i = pol; mosi_i = mb[7];
        repeat (4) @(negedge clk);
        ss_n_i = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            sck_i = ~pol;
            if (pha) mosi_i = mb[7-i];
            else     got = {got[6:0], miso_o};
            repeat (8) @(negedge clk);
            sck_i = pol;
            if (pha) got = {got[6:0], miso_o};
            else if (i < 7) mosi_i = mb[6-i];
            repeat (8) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        ss_n_i = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        longint     t1, t2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(SEL_CTRL, v); check("R1 ctrl", v, 8'h00);
        rd(SEL_STAT, v); check("R1 status", v, 8'h00);
        rd(SEL_DATA, v); check("R1 data", v, 8'h00);
        check("R1 ss_n_o", ss_n_o, 1);
        check("R1 sck_o", sck_o, 0);
        check("R1 irq_o", irq_o, 0);

        // R2 register map
        wr(SEL_CTRL, 8'hFF);
        rd(SEL_CTRL, v); check("R2 ctrl readback", v, 8'hDF);
        rd(SEL_NONE, v); check("R2 unused select", v, 8'h00);
        wr(SEL_CTRL, 8'h00);

        // R13 disabled port
        set_mode(C_MS);
        wr(SEL_DATA, 8'h77);
        repeat (40) @(negedge clk);
        check("R13 ss idle", ss_n_o, 1);
        check("R13 sck idle", sck_o, 0);
        rd(SEL_STAT, v); check("R13 no flag", v, 8'h00);

        // R3 R5 R6 R7: four clock modes at the fastest rate
        for (int m = 0; m < 4; m++) begin
            set_mode(C_EN | C_MS | (m[1] ? C_CPOL : 8'h00) | (m[0] ? C_CPHA : 8'h00));
            @(negedge clk);
            check("R5 idle level", sck_o, int'(m[1]));
            mxfer(8'hA5 ^ 8'(m * 37), 8'h3C + 8'(m * 29));
            check("R5 idle after byte", sck_o, int'(m[1]));
        end
        set_mode(C_EN | C_MS);
        mxfer(8'h01, 8'h80);
        mxfer(8'hFE, 8'h7F);

        // R4 rate codes
        for (int r = 0; r < 4; r++) begin
            set_mode(C_EN | C_MS | 8'(r));
            next_miso = 8'h5A;
            exp_q.push_back(8'hC6);
            wr(SEL_DATA, 8'hC6);
            @(posedge sck_o); t1 = cyc;
            @(posedge sck_o); t2 = cyc;
            check("R4 sck period", int'(t2 - t1), (r == 0) ? 4 : (r == 1) ? 16 : (r == 2) ? 64 : 128);
            @(posedge ss_n_o);
            wr(SEL_STAT, 8'h00);
        end

        // R8 interrupt gating, R10 write-one keeps flag
        set_mode(C_IE | C_EN | C_MS);
        next_miso = 8'h99;
        exp_q.push_back(8'h42);
        wr(SEL_DATA, 8'h42);
        @(posedge ss_n_o);
        @(negedge clk);
        check("R8 irq asserted", irq_o, 1);
        serial_ie_i = 1'b0; #1;
        check("R8 irq gated by global enable", irq_o, 0);
        serial_ie_i = 1'b1;
        wr(SEL_STAT, 8'hFF);
        rd(SEL_STAT, v); check("R10 write one keeps flag", v, 8'h80);
        check("R8 irq still set", irq_o, 1);
        set_mode(C_EN | C_MS);
        check("R8 irq gated by port enable", irq_o, 0);
        wr(SEL_STAT, 8'h00);

        // R9 collision
        set_mode(C_EN | C_MS | 8'h01);
        next_miso = 8'h5E;
        exp_q.push_back(8'hA5);
        wr(SEL_DATA, 8'hA5);
        repeat (20) @(negedge clk);
        wr(SEL_DATA, 8'h3C);
        rd(SEL_STAT, v); check("R9 collision flag", v, 8'h40);
        check("R9 byte continues", ss_n_o, 0);
        @(posedge ss_n_o);
        @(negedge clk);
        rd(SEL_STAT, v); check("R9 both flags", v, 8'hC0);
        rd(SEL_DATA, v); check("R9 collided write discarded", v, 8'h5E);
        wr(SEL_STAT, 8'h80);
        rd(SEL_STAT, v); check("R10 clear collision only", v, 8'h80);
        wr(SEL_STAT, 8'h00);

        // R11 slave mode, all clock modes, rate code 3 ignored
        for (int m = 0; m < 4; m++) begin
            set_mode(C_EN | 8'h03 | (m[1] ? C_CPOL : 8'h00) | (m[0] ? C_CPHA : 8'h00));
            wr(SEL_DATA, 8'hC3 + 8'(m));
            sxfer(m[1], m[0], 8'h96 ^ 8'(m * 51), v);
            check("R11 miso byte", v, 8'hC3 + 8'(m));
            check("R11 sck_o idle", sck_o, int'(m[1]));
            rd(SEL_DATA, v); check("R11 received byte", v, 8'h96 ^ 8'(m * 51));
            rd(SEL_STAT, v); check("R11 done flag", v, 8'h80);
            wr(SEL_STAT, 8'h00);
        end

        // R12 abort on early deselect, then fresh start
        set_mode(C_EN);
        wr(SEL_DATA, 8'h11);
        ss_n_i = 1'b0;
        repeat (8) @(negedge clk);
        for (int e = 0; e < 3; e++) begin
            sck_i = ~sck_i;
            repeat (8) @(negedge clk);
        end
        ss_n_i = 1'b1; sck_i = 1'b0;
        repeat (12) @(negedge clk);
        rd(SEL_STAT, v); check("R12 no flag on abort", v, 8'h00);
        wr(SEL_DATA, 8'h3A);
        sxfer(1'b0, 1'b0, 8'h6D, v);
        check("R12 restart miso", v, 8'h3A);
        rd(SEL_DATA, v); check("R12 restart received", v, 8'h6D);

        check("R3 scoreboard drained", exp_q.size(), 0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule